// File: doc/BRIEF.md
# UART Line Status Tracker

This block builds the eight-bit line status byte of one UART channel. On the receive side it holds a queue of up to 16 characters. Each stored character keeps its own parity, framing and break tags next to the data byte. The CPU sees the character at the head of the queue on a data output. It removes that character by strobing a receive-holding read. The tags of the head character show in the status byte. A summary bit reports whether any stored character carries a tag.

On the transmit side the block keeps only a count of the characters waiting in the holding stage. That stage is a single register when the queues are off, or a 16-deep queue when they are on. Together with an idle flag from the transmitter, the count gives the holding-empty and transmitter-empty flags and a transmit-ready interrupt request. Serial framing, baud timing and the shift registers themselves live outside the block. The block sees them only through the push port, the shift-register load strobe and the idle flag.

Status bit positions: bit 0 data ready, bit 1 overrun, bit 2 parity error, bit 3 framing error, bit 4 break, bit 5 transmit holding empty, bit 6 transmitter empty, bit 7 error in queue. All flags are registered, so a strobe seen on one rising edge shows on the status byte right after that edge.

Top module: `uart_line_status`

## Requirements
- R1: With reset asserted and tsrIdle high, lineStatus reads 0x60 after reset: no data, no errors, transmit side empty.
- R2: Bit 0 is 1 while at least one received character is stored. rxDataOut shows the oldest stored character, and characters leave in arrival order. Up to 16 are held with queues on (fifoEn=1), and one with queues off.
- R3: A push that arrives while storage is full (16 with queues on, 1 with queues off) is discarded and sets bit 1. An lsrRead pulse clears bit 1. If an lsrRead and a discarded push fall in the same cycle, the bit stays set.
- R4: Bits 2, 3 and 4 show the parity, framing and break tags of the head character. An lsrRead hides them until the head character changes through a read or a push into an empty store.
- R5: With queues on, a run of consecutive pushes that all carry the break tag stores only the first of them. The run ends at the next push without the break tag.
- R6: Bit 7 is 1 while any stored character carries a parity, framing or break tag. It falls after the rhrRead that removes the last tagged character.
- R7: With queues off, bit 5 falls after a thrWrite and rises after a tsrLoad. A second write before the load replaces the held character and does not add a second one.
- R8: With queues on, bit 5 is 1 only while the transmit queue is empty. A write into a full queue of 16 is dropped, so 16 loads empty it again.
- R9: Bit 6 is 1 exactly when bit 5 is 1 and tsrIdle is high.
- R10: txReadyIrq is high exactly when thrIntEn is high and bit 5 is 1.
- R11: Changing fifoEn empties both the receive store and the transmit count. Bits 0 to 4 and bit 7 then read 0, and bit 5 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoEn | input | 1 | 1 turns on the 16-deep queues; any change flushes them |
| thrIntEn | input | 1 | Enables the transmit-ready interrupt request |
| rxPush | input | 1 | Receiver offers a completed character |
| rxData | input | 8 | Received data byte |
| rxParErr | input | 1 | Parity tag of the offered character |
| rxFrmErr | input | 1 | Framing tag of the offered character |
| rxBreak | input | 1 | Break tag of the offered character |
| rhrRead | input | 1 | CPU read of the receive holding register; pops the head |
| lsrRead | input | 1 | CPU read of the status byte; clears bits 1 to 4 |
| thrWrite | input | 1 | CPU write of the transmit holding register |
| tsrLoad | input | 1 | Transmitter takes one character into its shift register |
| tsrIdle | input | 1 | Transmit shift register is empty |
| lineStatus | output | 8 | Line status byte |
| rxDataOut | output | 8 | Data byte of the head character |
| txReadyIrq | output | 1 | Transmit-ready interrupt request |

## Verification
The bench fills the receive queue to its limit and pushes one more character. A store that wrapped or overwrote would hand back the wrong sequence on drain, and one that lost the overrun would leave bit 1 low. It also sends a break run followed by a clean character, which catches a design that stores every break or that never ends the run. It walks tagged characters to the head one by one, with a status read in between. Flags tied to the tail instead of the head, or hidden for good after a status read, give the wrong bits 2 to 4. Last, it overfills the transmit queue, overwrites the single holding register and toggles fifoEn with data in flight, so a wrong transmit count or a missing flush shows up on bits 0, 5 and 6.

// File: rtl/uart_line_status_pkg.sv
package uart_line_status_pkg;

  localparam int unsigned LS_DATA_W = 8;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rxTag_t;

  typedef struct packed {
    rxTag_t                 tag;
    logic [LS_DATA_W-1:0]   data;
  } rxEntry_t;

  // strobes from control to receive storage
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } rxStrobe_t;

endpackage

// File: rtl/uart_line_status_store.sv
module uart_line_status_store
  import uart_line_status_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  rxStrobe_t stb,
  input  rxEntry_t  pushEntry,
  output rxEntry_t  headEntry
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  rxEntry_t         mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.push) wrPtr <= advance(wrPtr);
      if (stb.pop)  rdPtr <= advance(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= pushEntry;
  end

  assign headEntry = mem[rdPtr];

endmodule

// File: rtl/uart_line_status_ctrl.sv
module uart_line_status_ctrl
  import uart_line_status_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      fifoEn,
  input  logic      thrIntEn,
  input  logic      rxPush,
  input  rxTag_t    rxTag,
  input  logic      rhrRead,
  input  logic      lsrRead,
  input  logic      thrWrite,
  input  logic      tsrLoad,
  input  logic      tsrIdle,
  input  rxTag_t    headTag,
  output rxStrobe_t stb,
  output logic [7:0] lineStatus,
  output logic      txReadyIrq
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic             fifoEnQ;
  logic [CNT_W-1:0] rxCount;
  logic [CNT_W-1:0] txCount;
  logic [CNT_W-1:0] errCount;
  logic             overrun;
  logic             headSeen;
  logic             brkHold;

  logic [CNT_W-1:0] cap;
  logic             flush;
  logic             rxFull;
  logic             brkDup;
  logic             pushOk;
  logic             ovrSet;
  logic             popOk;
  logic             pushTagged;
  logic             popTagged;
  logic             headNew;
  logic             txDec;
  logic             txInc;
  logic             rxEmpty;
  logic             txEmpty;
  rxTag_t           shownTag;

  always_comb begin
    cap        = fifoEn ? FULL_CNT : ONE_CNT;
    flush      = (fifoEn != fifoEnQ);
    rxEmpty    = (rxCount == '0);
    rxFull     = (rxCount >= cap);
    brkDup     = fifoEn && rxTag.brk && brkHold;
    pushOk     = rxPush && !flush && !brkDup && !rxFull;
    ovrSet     = rxPush && !flush && !brkDup && rxFull;
    popOk      = rhrRead && !flush && !rxEmpty;
    pushTagged = pushOk && (|rxTag);
    popTagged  = popOk && (|headTag);
    headNew    = popOk || (pushOk && rxEmpty);
    txEmpty    = (txCount == '0);
    txDec      = tsrLoad && !flush && !txEmpty;
    txInc      = thrWrite && !flush && ((txCount < cap) || txDec);
  end

  assign stb.push  = pushOk;
  assign stb.pop   = popOk;
  assign stb.flush = flush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEnQ  <= 1'b0;
      rxCount  <= '0;
      txCount  <= '0;
      errCount <= '0;
      overrun  <= 1'b0;
      headSeen <= 1'b0;
      brkHold  <= 1'b0;
    end else begin
      fifoEnQ <= fifoEn;
      if (flush) begin
        rxCount  <= '0;
        txCount  <= '0;
        errCount <= '0;
        overrun  <= 1'b0;
        headSeen <= 1'b0;
        brkHold  <= 1'b0;
      end else begin
        rxCount  <= rxCount + CNT_W'(pushOk) - CNT_W'(popOk);
        txCount  <= txCount + CNT_W'(txInc) - CNT_W'(txDec);
        errCount <= errCount + CNT_W'(pushTagged) - CNT_W'(popTagged);
        if (ovrSet)       overrun <= 1'b1;
        else if (lsrRead) overrun <= 1'b0;
        if (headNew)      headSeen <= 1'b0;
        else if (lsrRead) headSeen <= 1'b1;
        if (rxPush)       brkHold <= rxTag.brk;
      end
    end
  end

  always_comb begin
    shownTag = (rxEmpty || headSeen) ? '0 : headTag;
    lineStatus = {(errCount != '0), (txEmpty && tsrIdle), txEmpty,
                  shownTag.brk, shownTag.frm, shownTag.par,
                  overrun, !rxEmpty};
    txReadyIrq = thrIntEn && txEmpty;
  end

endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uart_line_status_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoEn,
  input  logic       thrIntEn,
  input  logic       rxPush,
  input  logic [7:0] rxData,
  input  logic       rxParErr,
  input  logic       rxFrmErr,
  input  logic       rxBreak,
  input  logic       rhrRead,
  input  logic       lsrRead,
  input  logic       thrWrite,
  input  logic       tsrLoad,
  input  logic       tsrIdle,
  output logic [7:0] lineStatus,
  output logic [7:0] rxDataOut,
  output logic       txReadyIrq
);

  rxStrobe_t stb;
  rxTag_t    inTag;
  rxEntry_t  pushEntry;
  rxEntry_t  headEntry;

  assign inTag     = '{brk: rxBreak, frm: rxFrmErr, par: rxParErr};
  assign pushEntry = '{tag: inTag, data: rxData};
  assign rxDataOut = headEntry.data;

  uart_line_status_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fifoEn     (fifoEn),
    .thrIntEn   (thrIntEn),
    .rxPush     (rxPush),
    .rxTag      (inTag),
    .rhrRead    (rhrRead),
    .lsrRead    (lsrRead),
    .thrWrite   (thrWrite),
    .tsrLoad    (tsrLoad),
    .tsrIdle    (tsrIdle),
    .headTag    (headEntry.tag),
    .stb        (stb),
    .lineStatus (lineStatus),
    .txReadyIrq (txReadyIrq)
  );

  uart_line_status_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .pushEntry (pushEntry),
    .headEntry (headEntry)
  );

endmodule

// File: rtl/uart_line_status_chk.sv
module uart_line_status_chk (
  input logic       clk,
  input logic       rstN,
  input logic       fifoEn,
  input logic       thrIntEn,
  input logic       rxPush,
  input logic       rhrRead,
  input logic       thrWrite,
  input logic       tsrIdle,
  input logic [7:0] lineStatus,
  input logic       txReadyIrq,
  input logic       popStb,
  input logic       flushStb
);

  // R2: data ready only falls after a receive read or a flush
  p_ready_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineStatus[0]) |-> ($past(rhrRead) || $past(flushStb)));

  // R2: a pop strobe is only issued while data is held
  p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rstN)
    popStb |-> lineStatus[0]);

  // R3: with queues off, a push onto a held character raises overrun
  p_overrun_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn && lineStatus[0] && rxPush && !flushStb) |=> lineStatus[1]);

  // R4: head tags are only shown while data is held
  p_head_tags_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|lineStatus[4:2]) |-> lineStatus[0]);

  // R6: the summary bit implies something is stored
  p_summary_r6: assert property (@(posedge clk) disable iff (!rstN)
    lineStatus[7] |-> lineStatus[0]);

  // R7/R8: a write leaves the holding stage non-empty
  p_write_fills_r8: assert property (@(posedge clk) disable iff (!rstN)
    (thrWrite && !flushStb) |=> !lineStatus[5]);

  // R9: transmitter empty needs the holding stage empty and the shifter idle
  p_temt_r9: assert property (@(posedge clk) disable iff (!rstN)
    lineStatus[6] |-> (lineStatus[5] && tsrIdle));

  // R10: the request follows the enable and the holding-empty flag
  p_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    txReadyIrq |-> (thrIntEn && lineStatus[5]));

  // R11: a flush leaves the receive side empty
  p_flush_r11: assert property (@(posedge clk) disable iff (!rstN)
    flushStb |=> (!lineStatus[0] && lineStatus[5]));

endmodule

bind uart_line_status uart_line_status_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .fifoEn     (fifoEn),
  .thrIntEn   (thrIntEn),
  .rxPush     (rxPush),
  .rhrRead    (rhrRead),
  .thrWrite   (thrWrite),
  .tsrIdle    (tsrIdle),
  .lineStatus (lineStatus),
  .txReadyIrq (txReadyIrq),
  .popStb     (stb.pop),
  .flushStb   (stb.flush)
);

// File: tb/uart_line_status_bench.sv
`timescale 1ns/1ps
module uart_line_status_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fifoEn = 1'b1;
  logic       thrIntEn = 1'b0;
  logic       rxPush = 1'b0;
  logic [7:0] rxData = '0;
  logic       rxParErr = 1'b0;
  logic       rxFrmErr = 1'b0;
  logic       rxBreak = 1'b0;
  logic       rhrRead = 1'b0;
  logic       lsrRead = 1'b0;
  logic       thrWrite = 1'b0;
  logic       tsrLoad = 1'b0;
  logic       tsrIdle = 1'b1;
  logic [7:0] lineStatus;
  logic [7:0] rxDataOut;
  logic       txReadyIrq;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ [$];

  always #4 clk = ~clk;

  uart_line_status u_uart_line_status (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .thrIntEn(thrIntEn),
    .rxPush(rxPush), .rxData(rxData), .rxParErr(rxParErr),
    .rxFrmErr(rxFrmErr), .rxBreak(rxBreak), .rhrRead(rhrRead),
    .lsrRead(lsrRead), .thrWrite(thrWrite), .tsrLoad(tsrLoad),
    .tsrIdle(tsrIdle), .lineStatus(lineStatus), .rxDataOut(rxDataOut),
    .txReadyIrq(txReadyIrq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkStatus(input string tag, input logic [7:0] exp);
    @(negedge clk);
    chk(tag, lineStatus, exp);
  endtask

  // monitor: compares the head byte against the scoreboard on every read
  always @(negedge clk) begin
    if (rstN && rhrRead) begin
      if (expQ.size() == 0) chk("R2 read with empty scoreboard", rxDataOut, 8'hxx);
      else chk("R2 head byte order", rxDataOut, expQ.pop_front());
    end
  end

  // driver: offers one character and records it when it should be kept
  task automatic sendRx(input logic [7:0] d, input logic p, input logic f,
                        input logic b, input bit keep);
    @(posedge clk); #1;
    rxPush = 1'b1; rxData = d; rxParErr = p; rxFrmErr = f; rxBreak = b;
    if (keep) expQ.push_back(d);
    @(posedge clk); #1;
    rxPush = 1'b0; rxParErr = 1'b0; rxFrmErr = 1'b0; rxBreak = 1'b0;
  endtask

  task automatic readRhr();
    @(posedge clk); #1 rhrRead = 1'b1;
    @(posedge clk); #1 rhrRead = 1'b0;
  endtask

  task automatic readLsr();
    @(posedge clk); #1 lsrRead = 1'b1;
    @(posedge clk); #1 lsrRead = 1'b0;
  endtask

  task automatic writeThr();
    @(posedge clk); #1 thrWrite = 1'b1;
    @(posedge clk); #1 thrWrite = 1'b0;
  endtask

  task automatic loadTsr();
    @(posedge clk); #1 tsrLoad = 1'b1;
    @(posedge clk); #1 tsrLoad = 1'b0;
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (2) @(posedge clk);
    chkStatus("R1 reset status", 8'h60);
    chk("R1 reset irq", {7'd0, txReadyIrq}, 8'h00);

    // R2: simple ordering
    sendRx(8'h11, 0, 0, 0, 1);
    sendRx(8'h22, 0, 0, 0, 1);
    sendRx(8'h33, 0, 0, 0, 1);
    chkStatus("R2 data ready", 8'h61);
    for (int i = 0; i < 3; i++) readRhr();
    chkStatus("R2 drained", 8'h60);

    // R3: fill 16, one extra is dropped
    for (int i = 0; i < 16; i++) sendRx(8'h40 + 8'(i), 0, 0, 0, 1);
    sendRx(8'hEE, 0, 0, 0, 0);
    chkStatus("R3 overrun set", 8'h63);
    readLsr();
    chkStatus("R3 overrun cleared by status read", 8'h61);
    for (int i = 0; i < 16; i++) readRhr();
    chkStatus("R3 drained without extra", 8'h60);

    // R4 / R6: tags follow the head
    sendRx(8'hA0, 0, 0, 0, 1);
    sendRx(8'hB0, 1, 0, 0, 1);
    sendRx(8'hC0, 0, 1, 0, 1);
    chkStatus("R6 summary with clean head", 8'hE1);
    readRhr();
    chkStatus("R4 parity at head", 8'hE5);
    readLsr();
    chkStatus("R4 tags hidden after status read", 8'hE1);
    readRhr();
    chkStatus("R4 framing at new head", 8'hE9);
    readRhr();
    chkStatus("R6 summary clears with last tagged", 8'h60);

    // R5: break run keeps one character
    sendRx(8'h00, 0, 0, 1, 1);
    sendRx(8'h00, 0, 0, 1, 0);
    sendRx(8'h00, 0, 0, 1, 0);
    sendRx(8'h55, 0, 0, 0, 1);
    chkStatus("R5 break head", 8'hF1);
    readRhr();
    chkStatus("R5 clean after break", 8'h61);
    readRhr();
    chkStatus("R5 only two stored", 8'h60);

    // R8 / R9: transmit queue
    writeThr();
    chkStatus("R8 thre falls on write", 8'h00);
    tsrIdle = 1'b0;
    loadTsr();
    chkStatus("R9 shifter busy", 8'h20);
    tsrIdle = 1'b1;
    chkStatus("R9 shifter idle", 8'h60);
    for (int i = 0; i < 17; i++) writeThr();
    for (int i = 0; i < 15; i++) loadTsr();
    chkStatus("R8 one left after 15 loads", 8'h00);
    loadTsr();
    chkStatus("R8 empty after 16 loads", 8'h60);

    // R10: interrupt request
    thrIntEn = 1'b1;
    @(negedge clk);
    chk("R10 irq enabled and empty", {7'd0, txReadyIrq}, 8'h01);
    writeThr();
    @(negedge clk);
    chk("R10 irq low when holding full", {7'd0, txReadyIrq}, 8'h00);
    loadTsr();
    @(negedge clk);
    chk("R10 irq back after load", {7'd0, txReadyIrq}, 8'h01);
    thrIntEn = 1'b0;

    // R11: mode change flushes
    sendRx(8'h77, 1, 0, 0, 0);
    writeThr();
    chkStatus("R11 before flush", 8'h85);
    @(posedge clk); #1 fifoEn = 1'b0;
    repeat (2) @(posedge clk);
    chkStatus("R11 after flush", 8'h60);

    // R3 / R4 with queues off
    sendRx(8'h81, 0, 0, 0, 1);
    sendRx(8'h82, 0, 0, 0, 0);
    chkStatus("R3 single register overrun", 8'h63);
    readLsr();
    chkStatus("R3 cleared", 8'h61);
    readRhr();
    chkStatus("R3 single drained", 8'h60);
    sendRx(8'h91, 0, 1, 0, 1);
    chkStatus("R4 framing single", 8'hE9);
    readRhr();

    // R7: single holding register
    writeThr();
    chkStatus("R7 thre falls", 8'h00);
    writeThr();
    loadTsr();
    chkStatus("R7 overwrite leaves one", 8'h60);

    finishRun();
  end

endmodule